// File: doc/BRIEF.md
# Self-Checking Three-State Serial Adder

This block adds two binary numbers one digit per slot, least significant digit first. Each operand digit travels on a pair of rails. The positive rail high means one. The negative rail high means zero. Both rails low means no digit. Because zero is a real signal and not just a missing one, a dropped digit cannot pass for a zero. The adder keeps its carry in the same two-rail form. It produces a two-rail sum digit one cycle after each strobed slot.

Every add uses four complementary-pair detectors. Each detector looks at the three input digits, with at most one of them inverted, and recognises two of the eight legal combinations. A missing input, or an input with both rails high, matches no detector. In that case neither sum nor carry is formed, and a sticky alarm stops the adder until reset.

A word begins with a start pulse given together with its first digit. That pulse forces the carry-in to a valid zero. After the configured number of digits, the carry goes absent again. A further slot without a new start pulse is therefore caught as a fault.

Top module: `tsa_serial_adder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the alarm and leaves both sum rails low from the following cycle.
- R2: A digit is encoded {positive rail, negative rail}: 10 = one, 01 = zero, 00 = absent, 11 = malformed. For a strobed slot with valid A, B and carry-in, the sum pair in the next cycle is the low bit of A+B+carry-in in that encoding.
- R3: In any cycle after one without a strobe, both sum rails are low. The stored carry is kept across such gaps.
- R4: The carry-out of each digit is the carry-in of the next strobed digit. A start pulse with a strobe forces the carry-in of that digit to zero, even in the middle of a word.
- R5: A strobed slot where A or B is absent raises the alarm in the next cycle, and the sum pair stays absent.
- R6: A digit with both rails high is treated as a fault, the same as an absent digit.
- R7: Once raised, the alarm stays high until reset. While it is high, the sum rails stay low and strobes and start pulses have no effect.
- R8: After reset, and after the last digit of a word of WORD_LEN digits, the carry is absent. A strobe without a start pulse at that point raises the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_start | input | 1 | Marks the least significant digit of a word, sampled with slot |
| slot | input | 1 | Digit strobe: A and B are sampled in this cycle |
| a_pos | input | 1 | Operand A positive rail (one) |
| a_neg | input | 1 | Operand A negative rail (zero) |
| b_pos | input | 1 | Operand B positive rail (one) |
| b_neg | input | 1 | Operand B negative rail (zero) |
| sum_pos | output | 1 | Sum positive rail, one cycle after the slot |
| sum_neg | output | 1 | Sum negative rail, one cycle after the slot |
| alarm | output | 1 | Sticky fault flag |

## Verification
A wrong stored carry cannot be seen on the digit where it goes wrong. It shows on the sum of the next strobed digit, so the bench adds whole multi-digit words with long carry chains and places idle gaps between digits. If the stored carry were left present after the last digit, or forced absent too early, the error would appear one slot later: either an alarm that was not expected, or a missing alarm on the extra strobe after a word. A fault in the detectors or the gating shows in the very next cycle, as a sum pair with the wrong polarity, with both rails high, or present when it should be quiescent.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   // bit 1 = positive rail (one), bit 0 = negative rail (zero)
   typedef enum logic [1:0] {
      DIG_NONE = 2'b00,
      DIG_ZERO = 2'b01,
      DIG_ONE  = 2'b10,
      DIG_BAD  = 2'b11
   } dig_t;

   function automatic logic dig_valid(input dig_t d);
      return d[1] ^ d[0];
   endfunction
endpackage

// File: rtl/tsa_pair_match.sv
// Recognises one complementary pair of legal combinations: all three
// (possibly one inverted) digits at one, or all three at zero.
module tsa_pair_match #(
   parameter int INV_SEL = 0   // 0: none inverted, 1..3: invert digit INV_SEL-1
) (
   input  logic [2:0] pos_i,
   input  logic [2:0] neg_i,
   output logic       hit_hi_o,
   output logic       hit_lo_o
);
   logic [2:0] pos_eff;
   logic [2:0] neg_eff;

   if (INV_SEL < 0 || INV_SEL > 3) begin : g_bad_sel
      $error("tsa_pair_match: INV_SEL out of range");
   end

   for (genvar i = 0; i < 3; i++) begin : g_rail
      if (INV_SEL == i + 1) begin : g_swap
         assign pos_eff[i] = neg_i[i];
         assign neg_eff[i] = pos_i[i];
      end else begin : g_keep
         assign pos_eff[i] = pos_i[i];
         assign neg_eff[i] = neg_i[i];
      end
   end

   assign hit_hi_o = &pos_eff;
   assign hit_lo_o = &neg_eff;
endmodule

// File: rtl/tsa_digit_core.sv
// One digit position: four pair detectors feed the carry and sum rails.
module tsa_digit_core
   import tsa_pkg::*;
(
   input  dig_t a_i,
   input  dig_t b_i,
   input  dig_t c_i,
   output dig_t sum_o,
   output dig_t cout_o,
   output logic ok_o
);
   localparam int NPAIR = 4;

   logic [2:0]       pos_v;
   logic [2:0]       neg_v;
   logic [NPAIR-1:0] hi;
   logic [NPAIR-1:0] lo;
   logic             c_one, c_zero, s_one, s_zero;

   assign pos_v = {c_i[1], b_i[1], a_i[1]};
   assign neg_v = {c_i[0], b_i[0], a_i[0]};
   assign ok_o  = dig_valid(a_i) & dig_valid(b_i) & dig_valid(c_i);

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      tsa_pair_match #(.INV_SEL(k)) u_match (
         .pos_i   (pos_v),
         .neg_i   (neg_v),
         .hit_hi_o(hi[k]),
         .hit_lo_o(lo[k])
      );
   end

   // Carry: every "high" match has two or more ones among the real inputs.
   assign c_one  = ok_o & (|hi);
   assign c_zero = ok_o & (|lo);
   // Sum is the carry inverted, except for the all-alike pair (k = 0).
   assign s_one  = ok_o & (hi[0] | (|lo[NPAIR-1:1]));
   assign s_zero = ok_o & (lo[0] | (|hi[NPAIR-1:1]));

   assign cout_o = dig_t'({c_one, c_zero});
   assign sum_o  = dig_t'({s_one, s_zero});
endmodule

// File: rtl/tsa_word_ctrl.sv
// Holds the carry between slots and tracks the digit position in the word.
module tsa_word_ctrl
   import tsa_pkg::*;
#(
   parameter int WORD_LEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic take_i,       // a valid digit was added this cycle
   input  logic start_i,
   input  dig_t cout_i,
   output dig_t cin_o
);
   localparam int CNT_W = (WORD_LEN > 2) ? $clog2(WORD_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_LEN - 1);

   dig_t             cy_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] idx_now;

   if (WORD_LEN < 2) begin : g_bad_len
      $error("tsa_word_ctrl: WORD_LEN must be at least 2");
   end

   assign cin_o   = start_i ? DIG_ZERO : cy_q;
   assign idx_now = start_i ? '0 : idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cy_q  <= DIG_NONE;
         idx_q <= '0;
      end else if (take_i) begin
         if (idx_now == LAST) begin
            cy_q  <= DIG_NONE;
            idx_q <= '0;
         end else begin
            cy_q  <= cout_i;
            idx_q <= idx_now + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tsa_serial_adder.sv
module tsa_serial_adder
   import tsa_pkg::*;
#(
   parameter int WORD_LEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic word_start,
   input  logic slot,
   input  logic a_pos,
   input  logic a_neg,
   input  logic b_pos,
   input  logic b_neg,
   output logic sum_pos,
   output logic sum_neg,
   output logic alarm
);
   dig_t sum_d, cout_d, cin_d, sum_q;
   logic ok_d, accept, alarm_q;

   assign accept = slot & ~alarm_q;

   tsa_digit_core u_core (
      .a_i   (dig_t'({a_pos, a_neg})),
      .b_i   (dig_t'({b_pos, b_neg})),
      .c_i   (cin_d),
      .sum_o (sum_d),
      .cout_o(cout_d),
      .ok_o  (ok_d)
   );

   tsa_word_ctrl #(.WORD_LEN(WORD_LEN)) u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .take_i (accept & ok_d),
      .start_i(word_start),
      .cout_i (cout_d),
      .cin_o  (cin_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         alarm_q <= 1'b0;
         sum_q   <= DIG_NONE;
      end else begin
         alarm_q <= alarm_q | (accept & ~ok_d);
         sum_q   <= accept ? sum_d : DIG_NONE;
      end
   end

   assign sum_pos = sum_q[1];
   assign sum_neg = sum_q[0];
   assign alarm   = alarm_q;
endmodule

// File: rtl/tsa_serial_adder_chk.sv
module tsa_serial_adder_chk (
   input logic clk,
   input logic rst,
   input logic slot,
   input logic a_pos,
   input logic a_neg,
   input logic b_pos,
   input logic b_neg,
   input logic sum_pos,
   input logic sum_neg,
   input logic alarm
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (!alarm && !sum_pos && !sum_neg));

   p_rails_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
      !(sum_pos && sum_neg));

   p_valid_gives_digit_r2: assert property (@(posedge clk) disable iff (rst)
      (slot && !alarm && (a_pos ^ a_neg) && (b_pos ^ b_neg)) |=> (alarm || (sum_pos ^ sum_neg)));

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      !slot |=> (!sum_pos && !sum_neg));

   p_absent_alarm_r5: assert property (@(posedge clk) disable iff (rst)
      (slot && !(a_pos ^ a_neg)) |=> (alarm && !sum_pos && !sum_neg));

   p_double_rail_alarm_r6: assert property (@(posedge clk) disable iff (rst)
      (slot && b_pos && b_neg) |=> alarm);

   p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      alarm |=> alarm);

   p_alarm_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      alarm |-> (!sum_pos && !sum_neg));
endmodule

bind tsa_serial_adder tsa_serial_adder_chk u_chk (.*);

// File: tb/sim_tsa_serial_adder.sv
`timescale 1ns/1ps
module sim_tsa_serial_adder;
   localparam int WL = 4;
   localparam logic [1:0] D1 = 2'b10, D0 = 2'b01, DN = 2'b00, DB = 2'b11;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst = 1'b1, ws = 1'b0, slot = 1'b0;
   logic [1:0] a = DN, b = DN;
   logic sum_pos, sum_neg, alarm;

   tsa_serial_adder #(.WORD_LEN(WL)) u0 (
      .clk(clk), .rst(rst), .word_start(ws), .slot(slot),
      .a_pos(a[1]), .a_neg(a[0]), .b_pos(b[1]), .b_neg(b[0]),
      .sum_pos(sum_pos), .sum_neg(sum_neg), .alarm(alarm)
   );

   typedef struct { logic [1:0] s; logic al; string tag; } exp_t;
   exp_t q[$];
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   logic [1:0] m_cy = DN;
   int m_pos = 0;
   logic m_al = 0;

   function automatic bit okd(input logic [1:0] d);
      return d == D1 || d == D0;
   endfunction

   task automatic step(input logic r, input logic sl, input logic w,
                       input logic [1:0] da, input logic [1:0] db, input string tag);
      exp_t e;
      logic [1:0] ci;
      int s, p;
      @(negedge clk);
      rst = r; slot = sl; ws = w; a = da; b = db;
      e.tag = tag;
      if (r) begin
         m_cy = DN; m_pos = 0; m_al = 0; e.s = DN; e.al = 0;
      end else if (m_al || !sl) begin
         e.s = DN; e.al = m_al;
      end else begin
         ci = w ? D0 : m_cy;
         if (!okd(da) || !okd(db) || !okd(ci)) begin
            m_al = 1; e.s = DN; e.al = 1;
         end else begin
            s = int'(da == D1) + int'(db == D1) + int'(ci == D1);
            e.s = (s % 2 == 1) ? D1 : D0; e.al = 0;
            p = w ? 0 : m_pos;
            if (p == WL - 1) begin m_cy = DN; m_pos = 0; end
            else begin m_cy = (s >= 2) ? D1 : D0; m_pos = p + 1; end
         end
      end
      q.push_back(e);
   endtask

   task automatic add_word(input int x, input int y, input string tag);
      for (int i = 0; i < WL; i++)
         step(0, 1, i == 0, x[i] ? D1 : D0, y[i] ? D1 : D0, tag);
   endtask

   // monitor: one expected item per clock edge
   initial forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if ({sum_pos, sum_neg} !== e.s || alarm !== e.al) begin
            n_bad++;
            $display("FAIL %s: sum=%b alarm=%b expected sum=%b alarm=%b",
                     e.tag, {sum_pos, sum_neg}, alarm, e.s, e.al);
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      step(1, 0, 0, DN, DN, "R1");
      step(1, 0, 0, DN, DN, "R1");
      step(0, 0, 0, DN, DN, "R1");
      // R2: whole words, several operand patterns
      for (int x = 0; x < 16; x += 5)
         for (int y = 0; y < 16; y += 3)
            add_word(x, y, "R2");
      // R4 with R3 gaps: 15 + 1 carry chain, idle cycles between digits
      step(0, 1, 1, D1, D1, "R4");
      step(0, 0, 0, D1, D1, "R3");
      step(0, 1, 0, D1, D0, "R4");
      step(0, 0, 0, DN, DN, "R3");
      step(0, 0, 0, DN, DN, "R3");
      step(0, 1, 0, D1, D0, "R4");
      step(0, 1, 0, D1, D0, "R4");
      // R4: start pulse mid-word forces carry-in to zero
      step(0, 1, 1, D1, D1, "R4");
      step(0, 1, 1, D0, D0, "R4");
      step(0, 1, 0, D0, D0, "R4");
      // R8: strobe after a full word without a start pulse
      add_word(9, 7, "R2");
      step(0, 1, 0, D1, D0, "R8");
      step(0, 0, 0, DN, DN, "R7");
      step(1, 0, 0, DN, DN, "R1");
      // R8: strobe right after reset without a start pulse
      step(0, 1, 0, D0, D0, "R8");
      step(1, 0, 0, DN, DN, "R1");
      // R5: absent A, then R7 strobes and start pulses ignored
      step(0, 1, 1, D1, D0, "R5");
      step(0, 1, 0, DN, D1, "R5");
      step(0, 1, 1, D1, D1, "R7");
      step(0, 1, 0, D0, D1, "R7");
      step(0, 0, 0, DN, DN, "R7");
      step(1, 0, 0, DN, DN, "R1");
      // R5: absent B at first digit
      step(0, 1, 1, D1, DN, "R5");
      step(1, 0, 0, DN, DN, "R1");
      // R6: both rails on B, then on A
      step(0, 1, 1, D0, DB, "R6");
      step(0, 1, 1, D0, D0, "R7");
      step(1, 0, 0, DN, DN, "R1");
      step(0, 1, 1, DB, D1, "R6");
      step(1, 0, 0, DN, DN, "R1");
      add_word(6, 11, "R2");
      step(0, 0, 0, DN, DN, "R3");
      step(0, 0, 0, DN, DN, "R3");
      repeat (2) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule